// File: doc/BRIEF.md
# Edge-Gap Lock Monitor

This block decides whether a clock loop is locked. It compares the time between a rising edge of a reference clock and the matching rising edge of a feedback clock. Both clocks are asynchronous to a fast system clock. Each one passes through a synchronizer, and its rising edges become single-cycle pulses. The first edge of a pair to arrive starts a counter in system-clock cycles, and the other edge stops it. The count is the gap, and it does not matter which clock leads.

The reference edges are first thinned by a selectable ratio, so the comparison runs at the comparison rate and not at the raw reference rate. The feedback clock is expected to arrive already at that rate. The status output has hysteresis. It rises when a gap exceeds a high threshold. It falls only when a gap is below a lower threshold. Gaps between the two thresholds leave the status unchanged.

Top module: `phase_lock_monitor`

## Requirements
- R1: The gap of a pair is the number of system-clock cycles between the synchronized rising edge of one input and the synchronized rising edge of the other. The gap is the same whichever input leads. Two edges seen in the same cycle give a gap of 0.
- R2: After a measured gap greater than `ASSERT_GAP` (default 8), `lock_lost` becomes 1.
- R3: After a measured gap less than `RELEASE_GAP` (default 4), `lock_lost` becomes 0.
- R4: A gap from `RELEASE_GAP` to `ASSERT_GAP`, both limits included, leaves `lock_lost` at its previous value.
- R5: `rdiv_sel` selects the reference thinning ratio: 0 gives 1, 1 gives 4, 2 gives 16 and 3 gives 64. After reset, the first reference edge is used, and after it every Nth edge. Reference edges that are dropped take no part in a measurement.
- R6: While reset is high and after it is released, `lock_lost` is 1 until a measurement below `RELEASE_GAP` arrives.
- R7: If the second edge of a pair has not arrived when the counter reaches its maximum (63 cycles by default), the measurement ends with a gap of 63. That gap counts as above `ASSERT_GAP`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_clk_in | input | 1 | Asynchronous reference clock |
| fb_clk_in | input | 1 | Asynchronous feedback clock, at the comparison rate |
| rdiv_sel | input | 2 | Reference thinning ratio select (1, 4, 16, 64) |
| lock_lost | output | 1 | 1 = unlocked, 0 = locked |

## Verification
Directed pairs use gaps of exactly 3, 4, 8 and 9 cycles, which separate the release and assert boundaries from the hold band. Both orders of arrival are used, and a coincident pair checks that the measurement does not depend on which input leads. A lone reference edge exercises the saturation path. With a 1-in-4 ratio, pairs that must not lock (because their reference edges are dropped) are followed by a pair on a counted edge, which must lock. Seeded random gaps from 0 to 70 with a random leader are scored against a hysteresis model that saturates at 63.

// File: rtl/phlock_pkg.sv
package phlock_pkg;
    localparam int GAP_W     = 6;
    localparam int DIV_SEL_W = 2;
    localparam int DIV_CNT_W = 6;

    typedef logic [GAP_W-1:0] gap_t;

    typedef enum logic [1:0] {
        MS_IDLE,
        MS_WAIT_FB,
        MS_WAIT_REF
    } meter_st_t;

    typedef struct packed {
        logic valid;
        gap_t gap;
    } meas_t;

    // thinning ratio 4**sel
    function automatic logic [DIV_CNT_W:0] div_ratio(input logic [DIV_SEL_W-1:0] sel);
        return (DIV_CNT_W+1)'(1) << {sel, 1'b0};
    endfunction
endpackage

// File: rtl/phlock_edge_sync.sv
module phlock_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic rise
);
    logic [STAGES:0] shreg;

    always_ff @(posedge clk) begin
        if (rst) shreg <= '0;
        else     shreg <= {shreg[STAGES-1:0], async_in};
    end

    assign rise = shreg[STAGES-1] & ~shreg[STAGES];
endmodule

// File: rtl/phlock_prescale.sv
module phlock_prescale
    import phlock_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [DIV_SEL_W-1:0] sel,
    input  logic                 in_pulse,
    output logic                 out_pulse
);
    logic [DIV_CNT_W-1:0] cnt;
    logic [DIV_CNT_W:0]   ratio;

    assign ratio     = div_ratio(sel);
    assign out_pulse = in_pulse && (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (in_pulse) begin
            if ({1'b0, cnt} >= ratio - (DIV_CNT_W+1)'(1)) cnt <= '0;
            else                                           cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/phlock_gap_meter.sv
module phlock_gap_meter
    import phlock_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  ref_edge,
    input  logic  fb_edge,
    output meas_t meas
);
    localparam gap_t GAP_MAX = '1;

    meter_st_t st;
    gap_t      cnt;
    logic      closer;

    assign closer = (st == MS_WAIT_FB) ? fb_edge : ref_edge;

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= MS_IDLE;
            cnt  <= '0;
            meas <= '0;
        end else begin
            meas.valid <= 1'b0;
            case (st)
                MS_IDLE: begin
                    if (ref_edge && fb_edge) begin
                        meas.valid <= 1'b1;
                        meas.gap   <= '0;
                    end else if (ref_edge) begin
                        st  <= MS_WAIT_FB;
                        cnt <= gap_t'(1);
                    end else if (fb_edge) begin
                        st  <= MS_WAIT_REF;
                        cnt <= gap_t'(1);
                    end
                end
                MS_WAIT_FB, MS_WAIT_REF: begin
                    if (closer || cnt == GAP_MAX) begin
                        meas.valid <= 1'b1;
                        meas.gap   <= cnt;
                        st         <= MS_IDLE;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: st <= MS_IDLE;
            endcase
        end
    end

    // R7: a measurement never reports a gap above the counter span
    assert_sat_gap_R7: assert property (@(posedge clk) disable iff (rst)
        (st != MS_IDLE && !closer && cnt == GAP_MAX) |=> (meas.valid && meas.gap == GAP_MAX));
endmodule

// File: rtl/phase_lock_monitor.sv
module phase_lock_monitor
    import phlock_pkg::*;
#(
    parameter int ASSERT_GAP  = 8,
    parameter int RELEASE_GAP = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 ref_clk_in,
    input  logic                 fb_clk_in,
    input  logic [DIV_SEL_W-1:0] rdiv_sel,
    output logic                 lock_lost
);
    localparam gap_t ASSERT_T  = gap_t'(ASSERT_GAP);
    localparam gap_t RELEASE_T = gap_t'(RELEASE_GAP);

    logic  ref_rise, fb_rise, ref_used;
    meas_t meas;

    phlock_edge_sync #(.STAGES(SYNC_STAGES)) u_ref_sync (
        .clk(clk), .rst(rst), .async_in(ref_clk_in), .rise(ref_rise));

    phlock_edge_sync #(.STAGES(SYNC_STAGES)) u_fb_sync (
        .clk(clk), .rst(rst), .async_in(fb_clk_in), .rise(fb_rise));

    phlock_prescale u_pre (
        .clk(clk), .rst(rst), .sel(rdiv_sel), .in_pulse(ref_rise), .out_pulse(ref_used));

    phlock_gap_meter u_meter (
        .clk(clk), .rst(rst), .ref_edge(ref_used), .fb_edge(fb_rise), .meas(meas));

    always_ff @(posedge clk) begin
        if (rst) begin
            lock_lost <= 1'b1;
        end else if (meas.valid) begin
            if (meas.gap > ASSERT_T)       lock_lost <= 1'b1;
            else if (meas.gap < RELEASE_T) lock_lost <= 1'b0;
        end
    end

    assert_reset_unlocked_R6: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> lock_lost);

    assert_wide_gap_flags_R2: assert property (@(posedge clk) disable iff (rst)
        ($past(meas.valid) && $past(meas.gap) > ASSERT_T) |-> lock_lost);

    assert_narrow_gap_clears_R3: assert property (@(posedge clk) disable iff (rst)
        ($past(meas.valid) && $past(meas.gap) < RELEASE_T) |-> !lock_lost);

    assert_hold_without_meas_R4: assert property (@(posedge clk) disable iff (rst)
        !$stable(lock_lost) |-> $past(meas.valid));
endmodule

// File: tb/phase_lock_monitor_tb.sv
module phase_lock_monitor_tb;
    localparam int AG  = 8;
    localparam int RG  = 4;
    localparam int SAT = 63;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ref_clk_in = 1'b0;
    logic fb_clk_in  = 1'b0;
    logic [1:0] rdiv_sel = 2'd0;
    logic lock_lost;

    int checks = 0;
    int failures = 0;
    logic exp_lost;

    always #2 clk = ~clk;

    phase_lock_monitor #(.ASSERT_GAP(AG), .RELEASE_GAP(RG)) u_dut (
        .clk(clk), .rst(rst), .ref_clk_in(ref_clk_in), .fb_clk_in(fb_clk_in),
        .rdiv_sel(rdiv_sel), .lock_lost(lock_lost));

    function automatic logic model(input logic prev, input int d);
        int g = (d > SAT) ? SAT : d;
        if (g > AG) return 1'b1;
        if (g < RG) return 1'b0;
        return prev;
    endfunction

    function automatic string tag_of(input int d);
        int g = (d > SAT) ? SAT : d;
        if (d >= SAT) return "R7";
        if (g > AG)   return "R2";
        if (g < RG)   return "R3";
        return "R4";
    endfunction

    task automatic chk(input string req, input logic exp);
        checks++;
        if (lock_lost !== exp) begin
            failures++;
            $display("FAIL %s lock_lost actual=%b expected=%b", req, lock_lost, exp);
        end
    endtask

    task automatic settle();
        repeat (150) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        repeat (5) @(negedge clk);
        rst = 1'b0;
    endtask

    // one pulse pair: leader at t=0, follower at t=d, pulses 3 cycles wide
    task automatic pair(input bit lead_ref, input int d);
        for (int t = 0; t < d + 4; t++) begin
            logic a, b;
            a = (t < 3);
            b = (t >= d) && (t < d + 3);
            ref_clk_in = lead_ref ? a : b;
            fb_clk_in  = lead_ref ? b : a;
            @(negedge clk);
        end
        ref_clk_in = 1'b0;
        fb_clk_in  = 1'b0;
        settle();
    endtask

    task automatic lone_ref();
        ref_clk_in = 1'b1;
        repeat (3) @(negedge clk);
        ref_clk_in = 1'b0;
        settle();
    endtask

    initial begin
        #2000000;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd2718));
        do_reset();
        @(negedge clk);
        chk("R6 after reset", 1'b1);

        pair(1'b1, 2);  chk("R1 R3 ref leads gap 2", 1'b0);
        pair(1'b0, 6);  chk("R4 fb leads gap 6 holds 0", 1'b0);
        pair(1'b1, 9);  chk("R2 gap 9", 1'b1);
        pair(1'b0, 8);  chk("R4 gap 8 holds 1", 1'b1);
        pair(1'b0, 4);  chk("R4 gap 4 holds 1", 1'b1);
        pair(1'b0, 3);  chk("R3 gap 3", 1'b0);
        pair(1'b1, AG); chk("R4 gap 8 holds 0", 1'b0);
        lone_ref();     chk("R7 lone edge saturates", 1'b1);
        pair(1'b1, 0);  chk("R1 coincident edges", 1'b0);
        pair(1'b1, 70); chk("R7 gap beyond span", 1'b1);

        // R5: ratio 4, only the 1st and 5th reference edges count
        do_reset();
        rdiv_sel = 2'd1;
        @(negedge clk);
        chk("R6 reset again", 1'b1);
        lone_ref();
        for (int k = 0; k < 3; k++) pair(1'b1, 2);
        chk("R5 dropped reference edges do not lock", 1'b1);
        pair(1'b1, 2);
        chk("R5 counted reference edge locks", 1'b0);

        rdiv_sel = 2'd0;
        do_reset();
        exp_lost = 1'b1;
        for (int i = 0; i < 40; i++) begin
            int  d;
            bit  lr;
            d  = int'($urandom_range(70, 0));
            lr = bit'($urandom_range(1, 0));
            pair(lr, d);
            exp_lost = model(exp_lost, d);
            chk({"R1 ", tag_of(d), " random"}, exp_lost);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule